// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of an I2C-compatible serial memory. It runs on a fast system clock. It samples the bus clock and data lines through synchronizer stages, and drives SDA only as an open-drain pull-down enable. It finds Start and Stop conditions and checks the 8-bit device select byte against its chip-select pins. It then collects a 16-bit word address, high byte first, and turns the bus traffic into write and read strobes on a 64K x 8 synchronous memory port.

Several transfer types are supported: byte write, page write, current-address read, random read (a dummy write followed by a repeated Start) and sequential read. An input from the external write-cycle timer marks the array as busy. While it is set, the engine withholds the acknowledge for its own address, so a master can poll for the end of a write. A write-protect input blocks all array writes while keeping the bus protocol unchanged. After a Stop that closes a write with at least one stored byte, the engine pulses a request for the external timer to start a write cycle.

Top module: `tw_mem_slave`

## Requirements
- R1: A Start (SDA falling while SCL is high) restarts reception of a device select byte from any state, even in the middle of a byte. A Stop (SDA rising while SCL is high) returns the engine to idle. After a Stop, clocked bits are ignored until the next Start.
- R2: The device select byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `chip_sel`. Bit 0 selects the direction: 1 for read, 0 for write. Any other byte gets no acknowledge.
- R3: The slave pulls SDA low during the ninth clock of each byte it accepts: the select byte, both word-address bytes and every write data byte.
- R4: While `busy_i` is high, the select byte is not acknowledged. Once `busy_i` falls, it is acknowledged again.
- R5: The word address arrives high byte first, then low byte. The first data byte is written to that address with one `mem_we` pulse. `mem_we` and `mem_re` are never high together.
- R6: During a write, the pointer advances only in its low 7 bits, wrapping inside the 128-byte page. Bits 15:7 stay unchanged.
- R7: A current-address read returns the byte just after the last one accessed. The pointer is kept between transactions, and location 0xFFFF is followed by location 0.
- R8: A random read returns the byte at the word address sent in the preceding dummy write.
- R9: In a sequential read, each master acknowledge brings the next byte, with the address wrapping from 0xFFFF to 0. A master no-acknowledge releases SDA, and the pointer then points just past the last byte sent.
- R10: With `wp_i` high, write data bytes are still acknowledged, but no `mem_we` is issued and the array keeps its contents.
- R11: `wr_start` pulses for one cycle at a Stop only if that write transaction stored at least one byte. It does not pulse after reads, dummy writes or protected writes.
- R12: SDA is changed only while SCL is low. Read data goes out MSB first, and SDA is released during the master's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| chip_sel | input | 3 | Chip-select strap compared with select bits 3:1 |
| wp_i | input | 1 | Write protect, 1 makes the whole array read-only |
| busy_i | input | 1 | Write cycle in progress |
| mem_addr | output | 16 | Memory port address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data expected one cycle later |
| mem_rdata | input | 8 | Memory read data |
| wr_start | output | 1 | Request to start the timed write cycle |

## Verification
The main transfer path is run with byte writes, a page write that crosses its page end, and current-address reads. It is also run with random reads, with sequential reads that wrap past 0xFFFF, and with reads ended by a no-acknowledge. Comparing the returned bytes shows whether the pointer wraps per page on writes or across the whole array on reads. The refusal cases are: wrong chip-select bits, a wrong type nibble, the busy flag set, and write protect on. Each must show a different signature at the SDA pin, in the memory contents and in the `wr_start` count. A Start in the middle of a byte and bits clocked after a Stop confirm that the engine resynchronizes. Every clock where SCL is high, the bench compares the SDA pull-down against the slot it expects the slave to own.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tw_state_e;
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] pipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= 2'b00;
    else        pipe <= {pipe[0], 1'b1};
  end
  assign rst_n_s = pipe[1];
endmodule

// File: rtl/tw_line_mon.sv
module tw_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_full,
  input  logic              inc_page,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_n;

  always_comb begin
    ptr_n = ptr;
    if (load)          ptr_n = load_val;
    else if (inc_full) ptr_n = ptr + ADDR_W'(1);
    else if (inc_page) ptr_n = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_n;
  end
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          PAGE_W      = 7,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_TYPE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        chip_sel,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              wr_start
);
  localparam logic [3:0] BIT_LAST = 4'd8;

  logic rst_n_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tw_state_e  st, st_n;
  logic [3:0] cnt, cnt_n;
  logic [7:0] rxsr, rxsr_n, txsr, txsr_n, hi_q, hi_n;
  logic       is_rd, is_rd_n, mack, mack_n, rd_pend, rd_pend_n, dirty, dirty_n;
  logic       ptr_ld, ptr_inc, ptr_pg, addr_hit;
  logic [15:0] word_addr;
  logic [ADDR_W-1:0] ptr;

  tw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  tw_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign word_addr = {hi_q, rxsr};

  tw_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .load(ptr_ld), .load_val(word_addr[ADDR_W-1:0]),
    .inc_full(ptr_inc), .inc_page(ptr_pg), .ptr(ptr)
  );

  assign addr_hit  = (rxsr[7:4] == DEV_TYPE) && (rxsr[3:1] == chip_sel) && !busy_i;
  assign mem_addr  = ptr;
  assign mem_wdata = rxsr;

  always_comb begin
    st_n = st; cnt_n = cnt; rxsr_n = rxsr; txsr_n = txsr; hi_n = hi_q;
    is_rd_n = is_rd; mack_n = mack; dirty_n = dirty;
    mem_we = 1'b0; mem_re = 1'b0; wr_start = 1'b0;
    ptr_ld = 1'b0; ptr_inc = 1'b0; ptr_pg = 1'b0;
    if (rd_pend) txsr_n = mem_rdata;
    if (start_det) begin
      st_n = ST_DEV; cnt_n = '0; dirty_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; cnt_n = '0; wr_start = dirty; dirty_n = 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (scl_rise && cnt != BIT_LAST) begin
            rxsr_n = {rxsr[6:0], sda_s};
            cnt_n  = cnt + 4'd1;
          end else if (scl_fall && cnt == BIT_LAST) begin
            cnt_n = '0;
            if (st == ST_DEV) begin
              if (addr_hit) begin
                st_n    = ST_DEV_ACK;
                is_rd_n = rxsr[0];
                if (rxsr[0]) begin mem_re = 1'b1; ptr_inc = 1'b1; end
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st == ST_AHI) begin
              hi_n = rxsr; st_n = ST_AHI_ACK;
            end else if (st == ST_ALO) begin
              ptr_ld = 1'b1; st_n = ST_ALO_ACK;
            end else begin
              if (!wp_i) begin mem_we = 1'b1; ptr_pg = 1'b1; dirty_n = 1'b1; end
              st_n = ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK: if (scl_fall) st_n = is_rd ? ST_RD : ST_AHI;
        ST_AHI_ACK: if (scl_fall) st_n = ST_ALO;
        ST_ALO_ACK: if (scl_fall) st_n = ST_WR;
        ST_WR_ACK:  if (scl_fall) st_n = ST_WR;
        ST_RD: if (scl_fall) begin
          txsr_n = {txsr[6:0], 1'b0};
          if (cnt == 4'd7) begin cnt_n = '0; st_n = ST_RD_ACK; end
          else cnt_n = cnt + 4'd1;
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            if (!sda_s) begin mem_re = 1'b1; ptr_inc = 1'b1; end
          end else if (scl_fall) begin
            st_n = mack ? ST_RD : ST_IDLE;
          end
        end
        default: ;
      endcase
    end
    rd_pend_n = mem_re;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st <= ST_IDLE; cnt <= '0; rxsr <= '0; txsr <= '0; hi_q <= '0;
      is_rd <= 1'b0; mack <= 1'b0; rd_pend <= 1'b0; dirty <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; rxsr <= rxsr_n; txsr <= txsr_n; hi_q <= hi_n;
      is_rd <= is_rd_n; mack <= mack_n; rd_pend <= rd_pend_n; dirty <= dirty_n;
    end
  end

  always_comb begin
    case (st)
      ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: sda_oe = 1'b1;
      ST_RD:                                         sda_oe = ~txsr[7];
      default:                                       sda_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk
  import tw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              mem_we,
  input logic              mem_re,
  input logic              wp_i,
  input logic              busy_i,
  input logic              wr_start,
  input logic              stop_det,
  input logic [ADDR_W-1:0] mem_addr,
  input tw_state_e         st
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R12

  AST_NO_WRITE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp_i); // R10

  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV_ACK && $past(st) == ST_DEV) |-> !$past(busy_i)); // R4

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R5

  AST_WRSTART_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> stop_det); // R11

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]))); // R6
endmodule

bind tw_mem_slave tw_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .mem_we(mem_we),
  .mem_re(mem_re), .wp_i(wp_i), .busy_i(busy_i), .wr_start(wr_start),
  .stop_det(stop_det), .mem_addr(mem_addr), .st(st)
);

// File: tb/sim_tw_mem_slave.sv
`timescale 1ns/1ps
module sim_tw_mem_slave;
  localparam int H = 12;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, CS, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, CS, 1'b1};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl, sda_m, sda_line, wp, busy;
  logic sda_oe, mem_we, mem_re, wr_start;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic drive_ok, mon_en, done;
  int vectors = 0, fails = 0, wr_cnt = 0;

  logic [7:0] ram   [logic [15:0]];
  logic [7:0] ref_m [logic [15:0]];

  assign sda_line = sda_m & ~sda_oe;

  tw_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .chip_sel(CS), .wp_i(wp), .busy_i(busy), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .wr_start(wr_start)
  );

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= ram.exists(mem_addr) ? ram[mem_addr] : 8'h00;
    if (mem_we) ram[mem_addr] = mem_wdata;
    if (rst_n && wr_start) wr_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison: the slave may pull SDA during SCL high only in its own slot.
  always @(negedge clk) begin
    if (mon_en && scl) begin
      vectors++;
      if (sda_oe && !drive_ok) begin
        fails++;
        $display("FAIL R12 sda pulled outside slave slot actual=1 expected=0 t=%0t", $time);
      end
    end
  end

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    return ref_m.exists(a) ? ref_m[a] : 8'h00;
  endfunction

  task automatic preload(input logic [15:0] a, input logic [7:0] d);
    ram[a] = d; ref_m[a] = d;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, input logic slot, output logic got);
    @(negedge clk); sda_m = b;
    wait_n(H/2 - 1); drive_ok = slot;
    wait_n(H/2); scl = 1'b1;
    wait_n(H/2); got = sda_line;
    wait_n(H/2); scl = 1'b0;
  endtask

  task automatic bus_start();
    @(negedge clk); sda_m = 1'b1;
    wait_n(H); drive_ok = 1'b0; scl = 1'b1;
    wait_n(H); sda_m = 1'b0;
    wait_n(H); scl = 1'b0;
    wait_n(2);
  endtask

  task automatic bus_stop();
    @(negedge clk); sda_m = 1'b0;
    wait_n(H); drive_ok = 1'b0; scl = 1'b1;
    wait_n(H); sda_m = 1'b1;
    wait_n(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, g);
    clk_bit(1'b1, 1'b1, g);
    ack = !g;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b1, g);
      d[i] = g;
    end
    clk_bit(!mack, 1'b0, g);
  endtask

  task automatic addr_phase(input logic [15:0] a);
    logic ack;
    bus_start();
    send_byte(DEVW, ack); check("R2 select ack", ack, 1);
    send_byte(a[15:8], ack); check("R3 high address ack", ack, 1);
    send_byte(a[7:0], ack); check("R3 low address ack", ack, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic ack, g;
    logic [7:0] d;
    int wc;
    done = 0; mon_en = 0; drive_ok = 0;
    scl = 1; sda_m = 1; wp = 0; busy = 0; rst_n = 0;
    wait_n(6); rst_n = 1; wait_n(6);
    // Reset state
    check("R1 reset sda_oe", sda_oe, 0);
    check("R1 reset mem_we", mem_we, 0);
    check("R1 reset wr_start", wr_start, 0);
    check("R7 reset pointer", mem_addr, 16'h0000);
    mon_en = 1;

    // Byte write
    addr_phase(16'h1234);
    send_byte(8'hA5, ack); check("R3 data ack", ack, 1);
    ref_m[16'h1234] = 8'hA5;
    bus_stop();
    check("R5 byte write stored", ram.exists(16'h1234) ? ram[16'h1234] : 0, 8'hA5);
    check("R11 write start after byte write", wr_cnt, 1);

    // Busy: no ack while busy, ack after
    busy = 1;
    bus_start(); send_byte(DEVW, ack); check("R4 no ack while busy", ack, 0);
    busy = 0;
    bus_start(); send_byte(DEVW, ack); check("R4 ack after busy", ack, 1);
    bus_stop();
    check("R11 no write start without data", wr_cnt, 1);

    // Select byte mismatches
    bus_start(); send_byte({4'b1010, 3'b100, 1'b0}, ack); check("R2 chip select mismatch", ack, 0);
    bus_start(); send_byte({4'b1011, CS, 1'b0}, ack); check("R2 type nibble mismatch", ack, 0);
    bus_stop();

    // Current address read, pointer at 0x1235
    preload(16'h1235, 8'h3C);
    bus_start(); send_byte(DEVR, ack); check("R2 read select ack", ack, 1);
    recv_byte(1'b0, d); check("R7 R12 current read msb first", d, ref_rd(16'h1235));
    bus_stop();
    check("R11 no write start after read", wr_cnt, 1);

    // Page write crossing the page end
    addr_phase(16'h207E);
    foreach (ref_m[k]) begin end
    send_byte(8'h11, ack); check("R3 page data ack", ack, 1);
    send_byte(8'h22, ack); check("R3 page data ack", ack, 1);
    send_byte(8'h33, ack); check("R3 page data ack", ack, 1);
    send_byte(8'h44, ack); check("R3 page data ack", ack, 1);
    ref_m[16'h207E] = 8'h11; ref_m[16'h207F] = 8'h22;
    ref_m[16'h2000] = 8'h33; ref_m[16'h2001] = 8'h44;
    bus_stop();
    check("R6 page byte 207F", ram.exists(16'h207F) ? ram[16'h207F] : 0, ref_rd(16'h207F));
    check("R6 page wrap 2000", ram.exists(16'h2000) ? ram[16'h2000] : 0, ref_rd(16'h2000));
    check("R6 page wrap 2001", ram.exists(16'h2001) ? ram[16'h2001] : 0, ref_rd(16'h2001));
    check("R6 no spill to 2080", ram.exists(16'h2080) ? 1 : 0, 0);
    check("R11 write start after page write", wr_cnt, 2);

    // Random + sequential read
    preload(16'h2002, 8'h55); preload(16'h2003, 8'h66);
    addr_phase(16'h2000);
    bus_start(); send_byte(DEVR, ack); check("R8 read select ack", ack, 1);
    recv_byte(1'b1, d); check("R8 random read", d, ref_rd(16'h2000));
    recv_byte(1'b1, d); check("R9 sequential second", d, ref_rd(16'h2001));
    recv_byte(1'b0, d); check("R9 sequential third", d, ref_rd(16'h2002));
    bus_stop();
    check("R11 no write start after dummy write", wr_cnt, 2);
    bus_start(); send_byte(DEVR, ack);
    recv_byte(1'b0, d); check("R9 pointer after noack", d, ref_rd(16'h2003));
    bus_stop();

    // Array-end wrap on reads
    preload(16'hFFFF, 8'h77); preload(16'h0000, 8'h88); preload(16'h0001, 8'h99);
    addr_phase(16'hFFFF);
    bus_start(); send_byte(DEVR, ack);
    recv_byte(1'b1, d); check("R9 read at FFFF", d, ref_rd(16'hFFFF));
    recv_byte(1'b0, d); check("R9 wrap to 0000", d, ref_rd(16'h0000));
    bus_stop();
    bus_start(); send_byte(DEVR, ack);
    recv_byte(1'b0, d); check("R7 current read after wrap", d, ref_rd(16'h0001));
    bus_stop();

    // Write protect
    preload(16'h0300, 8'h5A);
    wp = 1; wc = wr_cnt;
    addr_phase(16'h0300);
    send_byte(8'hEE, ack); check("R10 protected data still acked", ack, 1);
    bus_stop();
    wp = 0;
    check("R10 R11 no write start when protected", wr_cnt, wc);
    addr_phase(16'h0300);
    bus_start(); send_byte(DEVR, ack);
    recv_byte(1'b0, d); check("R10 protected location unchanged", d, ref_rd(16'h0300));
    bus_stop();

    // Start in the middle of a byte
    preload(16'h0301, 8'hC4);
    bus_start(); send_byte(DEVW, ack);
    clk_bit(1'b0, 1'b0, g); clk_bit(1'b1, 1'b0, g); clk_bit(1'b0, 1'b0, g);
    bus_start(); send_byte(DEVR, ack); check("R1 select ack after restart", ack, 1);
    recv_byte(1'b0, d); check("R1 read after restart", d, ref_rd(16'h0301));
    bus_stop();

    // Bits after Stop without Start are ignored
    for (int i = 7; i >= 0; i--) clk_bit(DEVR[i], 1'b0, g);
    clk_bit(1'b1, 1'b0, g); check("R1 no ack without start", g, 1);
    bus_stop();
    check("R5 no stray write", ram.exists(16'h0302) ? 1 : 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule